// File: doc/BRIEF.md
# Wormhole Packet Switch Core

This block is a small packet switch with an equal number of input and output ports, joined by a crossbar. Packets are sequences of flits. Each flit carries a two-bit kind field. The first flit of a packet names an output port. That flit moves on as soon as it has been examined, so the switch does not wait for the rest of the packet. From then on, the chosen output belongs to that packet. The following flits pass through the crossbar on the same path with no further routing work. The last flit gives the output back as it leaves.

Each input has a shallow flit FIFO. When several inputs ask for the same free output, a round-robin arbiter for that output picks one of them. A packet that is blocked stays where it is. It fills the small FIFO, and `in_ready` then falls toward the sender. No flit is ever dropped.

Top module: `wh_switch`

## Requirements
- R1: While reset is held and in the cycle after it is released, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A flit is DATA_W+2 bits wide. Its top two bits are the kind field: 00 opens a packet, 01 is a middle flit, 10 closes a packet, and 11 is a packet of one flit. The low log2(NPORT) data bits of an opening or one-flit packet select the output. A flit leaves only on the output its packet selected.
- R3: Suppose an opening flit is accepted at clock edge k on an input and its output is free with no rival. That flit is presented on its output after edge k+1 and not after edge k.
- R4: After the opening flit has left, a flit already waiting in the owning FIFO is presented in the next cycle. An unstalled packet therefore leaves one flit per cycle.
- R5: From the opening flit to the closing flit, an output carries only that packet's flits. No flit of another input appears in between.
- R6: An output becomes free when a closing flit or a one-flit packet leaves. In the cycle after that, the output presents nothing until a new packet has been granted. A waiting packet from another input is then served.
- R7: An output that is contended grants the first requesting input at or after its pointer, counting upward with wrap-around. The pointer starts at input 0 and moves to the input just past each winner. With inputs 1, 2 and 3 contending, the order of service is 1, 2, 3. A later contention between inputs 0 and 3 is then served 0 first.
- R8: While `out_valid` is high and `out_ready` is low, the output flit holds steady. An input whose FIFO holds DEPTH flits lowers `in_ready`. Every accepted flit is delivered, with no loss or reordering within its packet stream.
- R9: Packets bound for different outputs are presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NPORT | Per input: a flit is offered |
| in_ready | output | NPORT | Per input: the FIFO has room |
| in_flit | input | NPORT*(DATA_W+2) | Flits offered, input i at slice i |
| out_valid | output | NPORT | Per output: a flit is presented |
| out_ready | input | NPORT | Per output: the downstream side takes the flit |
| out_flit | output | NPORT*(DATA_W+2) | Flits presented, output j at slice j |

## Verification
Two events can fall in the same cycle. One is a closing flit leaving an output. The other is a rival input's opening flit, already waiting at its FIFO head for that same output. The bench provokes this by sending a long packet and a one-flit packet to one output back to back. It also sends contended one-flit packets from three inputs at once. It judges the result by the order of service per output and by checking that no foreign flit falls inside a packet. A second overlap is back-pressure on one output while packets to another output keep moving. The random phase provokes this by toggling `out_ready` per output. A scoreboard keyed by source and destination judges it.

// File: rtl/wh_pkg.sv
// Shared flit kind encoding and helper predicates for the wormhole switch.
package wh_pkg;
    typedef enum logic [1:0] {
        FK_OPEN   = 2'b00,
        FK_MID    = 2'b01,
        FK_CLOSE  = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    // True for a flit that asks for an output.
    function automatic logic kind_opens(input logic [1:0] k);
        return (k == FK_OPEN) || (k == FK_SINGLE);
    endfunction

    // True for a flit that gives its output back when it leaves.
    function automatic logic kind_closes(input logic [1:0] k);
        return (k == FK_CLOSE) || (k == FK_SINGLE);
    endfunction
endpackage

// File: rtl/wh_fifo.sv
// Shallow flit FIFO for one input. The head is read straight from storage.
// Assumes DEPTH >= 2. A push while full is refused, because ready is !full.
module wh_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign dout    = mem[rd_ptr];

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (!do_push && do_pop) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/wh_rr_arb.sv
// Round-robin arbiter: grants the first request at or above the pointer,
// with wrap-around. When a grant is taken, the pointer moves just past the winner.
module wh_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [IW-1:0] gnt_idx,
    output logic          any_req
);
    logic [IW-1:0] ptr;
    logic          found;

    assign any_req = |req;

    // Search for the first requester starting at the pointer.
    always_comb begin
        gnt_idx = '0;
        found   = 1'b0;
        for (int off = 0; off < N; off++) begin
            if (!found && req[(int'(ptr) + off) % N]) begin
                found   = 1'b1;
                gnt_idx = IW'((int'(ptr) + off) % N);
            end
        end
    end

    // Move the priority pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (take) ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
endmodule

// File: rtl/wh_out_port.sv
// Control for one output. While free, it grants one requesting input and locks
// to it in the next cycle. While locked, it forwards that input's FIFO head and
// pops it when the flit is taken. A closing or one-flit flit unlocks it.
module wh_out_port
    import wh_pkg::*;
#(
    parameter int N      = 4,
    parameter int DATA_W = 8,
    parameter int FLIT_W = DATA_W + 2,
    parameter int IW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic [N-1:0]      head_valid,
    input  logic [N*FLIT_W-1:0] head_flit,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_flit,
    output logic [N-1:0]      pop
);
    logic          locked;
    logic [IW-1:0] owner, gnt_idx;
    logic          any_req, take, fire;
    logic [1:0]    sel_kind;

    assign take      = !locked && any_req;
    assign out_flit  = head_flit[int'(owner)*FLIT_W +: FLIT_W];
    assign sel_kind  = out_flit[DATA_W +: 2];
    assign out_valid = locked && head_valid[owner];
    assign fire      = out_valid && out_ready;
    assign pop       = fire ? (N'(1) << owner) : '0;

    wh_rr_arb #(.N(N), .IW(IW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .take    (take),
        .gnt_idx (gnt_idx),
        .any_req (any_req)
    );

    // Reservation state: claim on grant, release on a closing flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= '0;
        end else if (take) begin
            locked <= 1'b1;
            owner  <= gnt_idx;
        end else if (fire && kind_closes(sel_kind)) begin
            locked <= 1'b0;
        end
    end
endmodule

// File: rtl/wh_switch.sv
// Wormhole switch core. Each input has a FIFO. Each output has a round-robin
// reservation controller, and a crossbar mux joins them. Assumes DATA_W is at
// least log2(NPORT). The destination sits in the low data bits of an opening flit.
module wh_switch
    import wh_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    localparam int FLIT_W = DATA_W + 2,
    localparam int IW     = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    input  logic [NPORT*FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready,
    output logic [NPORT*FLIT_W-1:0] out_flit
);
    logic [NPORT*FLIT_W-1:0] head_flit;
    logic [NPORT-1:0]        head_valid, pop_in;
    logic [NPORT-1:0]        req_m [NPORT];
    logic [NPORT-1:0]        pop_m [NPORT];

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        logic empty_i, full_i;
        wh_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i]),
            .din   (in_flit[i*FLIT_W +: FLIT_W]),
            .pop   (pop_in[i]),
            .dout  (head_flit[i*FLIT_W +: FLIT_W]),
            .empty (empty_i),
            .full  (full_i)
        );
        assign head_valid[i] = !empty_i;
        assign in_ready[i]   = !full_i;
    end

    // Route decode: an opening head requests the output named in its data.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_m[o][i] = head_valid[i]
                    && kind_opens(head_flit[i*FLIT_W + DATA_W +: 2])
                    && (head_flit[i*FLIT_W +: IW] == IW'(o));
            end
        end
    end

    // Merge per-output pop vectors into one pop per input.
    always_comb begin
        pop_in = '0;
        for (int o = 0; o < NPORT; o++) pop_in = pop_in | pop_m[o];
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        wh_out_port #(.N(NPORT), .DATA_W(DATA_W), .FLIT_W(FLIT_W), .IW(IW)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .req        (req_m[o]),
            .head_valid (head_valid),
            .head_flit  (head_flit),
            .out_ready  (out_ready[o]),
            .out_valid  (out_valid[o]),
            .out_flit   (out_flit[o*FLIT_W +: FLIT_W]),
            .pop        (pop_m[o])
        );
    end
endmodule

// File: rtl/wh_switch_chk.sv
// Port-level properties of the wormhole switch, bound to every instance.
module wh_switch_chk #(
    parameter int NPORT  = 4,
    parameter int DATA_W = 8,
    parameter int FLIT_W = DATA_W + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        in_valid,
    input logic [NPORT-1:0]        in_ready,
    input logic [NPORT-1:0]        out_valid,
    input logic [NPORT-1:0]        out_ready,
    input logic [NPORT*FLIT_W-1:0] out_flit
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0) && (in_ready == '1));

    for (genvar o = 0; o < NPORT; o++) begin : g_o
        logic [1:0] kind;
        assign kind = out_flit[o*FLIT_W + DATA_W +: 2];

        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o]
            |=> out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W]));

        assert_no_intrude_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_ready[o] && (kind == 2'b00)
            |=> !out_valid[o] || (kind == 2'b01) || (kind == 2'b10));

        assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_ready[o] && kind[1]
            |=> !out_valid[o]);
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_i
        assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(in_ready[i]) |-> $past(in_valid[i]));
    end
endmodule

bind wh_switch wh_switch_chk #(.NPORT(NPORT), .DATA_W(DATA_W), .FLIT_W(FLIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit)
);

// File: tb/wh_switch_tb.sv
// Bench: directed corner cases plus seeded random traffic. A scoreboard is
// keyed by source and destination. Flit data layout: {src[1:0], seq[3:0], dst[1:0]}.
module wh_switch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 8;
    localparam int FW = DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    in_valid = '0;
    logic [NP-1:0]    out_ready = '0;
    logic [NP*FW-1:0] in_flit = '0;
    logic [NP-1:0]    in_ready, out_valid;
    logic [NP*FW-1:0] out_flit;

    int n_chk = 0;
    int n_bad = 0;
    logic [FW-1:0] tx_q [NP][$];
    logic [FW-1:0] exp_q [NP*NP][$];
    logic [1:0]    ord [NP][$];
    logic [NP-1:0] hs = '0;
    logic [NP-1:0] rdy = '1;
    bit            rmode = 1'b0;
    bit            open_o [NP];
    logic [1:0]    osrc [NP];
    logic [3:0]    seq = '0;

    wh_switch #(.NPORT(NP), .DATA_W(DW), .DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
        .out_flit(out_flit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input logic [1:0] k, input int s, input int d);
        return {k, 2'(s), seq, 2'(d)};
    endfunction

    // Queue a packet of len flits from input s to output d, and record it as expected.
    task automatic send_pkt(input int s, input int d, input int len);
        logic [FW-1:0] f;
        for (int n = 0; n < len; n++) begin
            if (len == 1)           f = mk(2'b11, s, d);
            else if (n == 0)        f = mk(2'b00, s, d);
            else if (n == len - 1)  f = mk(2'b10, s, d);
            else                    f = mk(2'b01, s, d);
            seq = seq + 1'b1;
            tx_q[s].push_back(f);
            exp_q[s*NP + d].push_back(f);
        end
    endtask

    function automatic bit busy();
        for (int i = 0; i < NP; i++) if (tx_q[i].size() != 0) return 1'b1;
        for (int i = 0; i < NP*NP; i++) if (exp_q[i].size() != 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic wait_idle();
        int n = 0;
        while (busy() && n < 5000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
        chk(n < 5000, "R8 drain", n, 0);
    endtask

    task automatic wait_hs(input int i);
        do @(negedge clk); while (!(in_valid[i] && in_ready[i]));
    endtask

    function automatic logic [FW-1:0] oflit(input int o);
        return out_flit[o*FW +: FW];
    endfunction

    // Input driver: pops accepted flits, then presents the next ones away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            for (int i = 0; i < NP; i++) if (hs[i]) void'(tx_q[i].pop_front());
            #1;
            for (int i = 0; i < NP; i++) begin
                in_valid[i] = rst_n && (tx_q[i].size() != 0);
                in_flit[i*FW +: FW] = (tx_q[i].size() != 0) ? tx_q[i][0] : '0;
            end
            for (int o = 0; o < NP; o++)
                out_ready[o] = rmode ? (($urandom % 4) != 0) : rdy[o];
        end
    end

    // Monitor at the falling edge: records handshakes and checks delivered flits.
    always @(negedge clk) begin
        hs = rst_n ? (in_valid & in_ready) : '0;
        if (rst_n) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    logic [FW-1:0] f;
                    logic [1:0] k, s;
                    f = oflit(o);
                    k = f[FW-1 -: 2];
                    s = f[7:6];
                    if (k == 2'b00 || k == 2'b11) begin
                        chk(f[1:0] == 2'(o), "R2 route", f[1:0], o);
                        chk(!open_o[o], "R5 new packet inside open one", 1, 0);
                        ord[o].push_back(s);
                        open_o[o] = (k == 2'b00);
                        osrc[o] = s;
                    end else begin
                        chk(open_o[o] && osrc[o] == s, "R5 foreign flit", s, osrc[o]);
                        if (k == 2'b10) open_o[o] = 1'b0;
                    end
                    if (exp_q[s*NP + o].size() == 0) chk(0, "R8 unexpected flit", f, 0);
                    else begin
                        chk(exp_q[s*NP + o][0] == f, "R8 order", f, exp_q[s*NP + o][0]);
                        void'(exp_q[s*NP + o].pop_front());
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [FW-1:0] held;
        void'($urandom(32'd1234));
        for (int o = 0; o < NP; o++) open_o[o] = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R1 out_valid in reset", out_valid, 0);
        chk(in_ready == '1, "R1 in_ready in reset", in_ready, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready == '1, "R1 in_ready after reset", in_ready, 4'hF);

        // R3 timing, R4 streaming, R6 release.
        send_pkt(0, 2, 4);
        wait_hs(0);
        @(negedge clk);
        chk(out_valid[2] == 1'b0, "R3 too early", out_valid[2], 0);
        @(negedge clk);
        chk(out_valid[2] && oflit(2)[9:8] == 2'b00 && oflit(2)[7:6] == 2'd0,
            "R3 header presented", oflit(2), 10'h0);
        for (int n = 1; n < 4; n++) begin
            @(negedge clk);
            chk(out_valid[2] && oflit(2)[9:8] == ((n == 3) ? 2'b10 : 2'b01),
                "R4 back-to-back flit", {out_valid[2], oflit(2)[9:8]}, n);
        end
        @(negedge clk);
        chk(!out_valid[2], "R6 idle after close", out_valid[2], 0);
        wait_idle();

        // R6: a one-flit packet releases, and the waiting rival is then served.
        for (int i = 0; i < NP; i++) ord[i].delete();
        send_pkt(1, 3, 1);
        send_pkt(2, 3, 2);
        wait_idle();
        chk(ord[3].size() == 2 && ord[3][0] == 2'd1 && ord[3][1] == 2'd2,
            "R6 handover order", ord[3].size(), 2);

        // R7: round-robin order on output 0.
        send_pkt(3, 0, 1); send_pkt(1, 0, 1); send_pkt(2, 0, 1);
        wait_idle();
        send_pkt(0, 0, 1); send_pkt(3, 0, 1);
        wait_idle();
        chk(ord[0].size() == 5, "R7 count", ord[0].size(), 5);
        if (ord[0].size() == 5) begin
            chk(ord[0][0] == 1 && ord[0][1] == 2 && ord[0][2] == 3, "R7 first round",
                {ord[0][0], ord[0][1], ord[0][2]}, 6'b011011);
            chk(ord[0][3] == 0 && ord[0][4] == 3, "R7 second round",
                {ord[0][3], ord[0][4]}, 4'b0011);
        end

        // R8: back-pressure fills the FIFO and holds the output steady.
        rdy[2] = 1'b0;
        send_pkt(0, 2, 4);
        repeat (6) @(negedge clk);
        chk(in_ready[0] == 1'b0, "R8 in_ready low when full", in_ready[0], 0);
        chk(out_valid[2] && oflit(2)[9:8] == 2'b00, "R8 stalled header shown",
            oflit(2), 0);
        held = oflit(2);
        @(negedge clk);
        chk(out_valid[2] && oflit(2) == held, "R8 held stable", oflit(2), held);
        rdy[2] = 1'b1;
        wait_idle();

        // R9: two outputs at once.
        send_pkt(1, 3, 2);
        send_pkt(2, 1, 2);
        wait_hs(1);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid[3] && out_valid[1], "R9 concurrent outputs", out_valid, 4'b1010);
        wait_idle();

        // Random traffic with random back-pressure.
        rmode = 1'b1;
        for (int p = 0; p < 300; p++) begin
            int s;
            s = $urandom % NP;
            while (tx_q[s].size() > 12) @(negedge clk);
            send_pkt(s, $urandom % NP, 1 + ($urandom % 4));
            if (($urandom % 3) == 0) @(negedge clk);
        end
        while (tx_q[0].size() + tx_q[1].size() + tx_q[2].size() + tx_q[3].size() != 0)
            @(negedge clk);
        rmode = 1'b0;
        wait_idle();
        chk(!busy(), "R8 all flits delivered", busy(), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule